// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves bytes over one bidirectional data line and produces the shift clock on a second line. Its timing comes from a machine cycle of six states. Each state has two phases, so a cycle has twelve phase slots, numbered 0 (S1P1) through 11 (S6P2). A phase-advance strobe `ph_tick` steps a slot counter inside the block. Exactly one bit moves per machine cycle, and the least significant bit goes first.

A buffer write starts a transmission. The byte and a marker 1 are loaded above the most significant bit of a nine-bit shift register. The register shifts right, and the end of the frame is found when only the marker is left above the last data bit.

A reception starts when receive-enable is high, the receive-done flag is low and no transmission is pending. The receive register is preset to all ones with a single 0 at the right. Sampled bits are shifted in from the right, and the frame ends when the 0 reaches the leftmost position. Each direction has a sticky done flag that stays set until its clear input is pulsed.

Top module: `sio_sync_port`

## Requirements
- R1: After reset, `sd_oe`=0, `sclk`=1, `tx_done`=0, `rx_done`=0, `rx_byte`=0, and the slot counter is at slot 0 (S1P1).
- R2: The slot counter advances by one slot, wrapping from 11 to 0, on each clock where `ph_tick`=1. It holds on every other clock. All timings below count ticks, not clocks.
- R3: Call the machine cycle in which an accepted `wr_buf` arrives cycle 0. `sd_oe` stays 0 through cycle 1 and rises at slot 0 of cycle 2, leaving one full machine cycle in between. A write taken on the ticking edge of slot 11 belongs to that cycle.
- R4: During active transmit cycle k (cycles 2+k, k=0..7), `sd_out` equals bit k of the written byte.
- R5: `sclk` is 0 in slots 4 to 9 (S3 to S5) of every machine cycle in which a transfer is shifting. It is 1 in all other slots and whenever the port is idle.
- R6: `sd_oe` falls and `tx_done` rises after the slot-0 tick of cycle 10. `tx_done` stays 1 until `clr_tx_done` is pulsed.
- R7: If, at the slot-11 tick of cycle 0, `rx_en`=1, `rx_done` is 0 (or being cleared) and no transmission is pending, then the shift clock runs from cycle 2. `sd_oe` stays 0 throughout the reception.
- R8: `sd_in` is sampled at slot 9 (S5P2) of each active receive cycle 2+k. That sample becomes bit k of `rx_byte`.
- R9: `rx_byte` is updated and `rx_done` rises after the slot-0 tick of cycle 10. `rx_byte` never changes at any other time.
- R10: No reception starts while `rx_done`=1 or `rx_en`=0.
- R11: A `wr_buf` arriving while a transmission or reception is pending or active is ignored.
- R12: A reception cannot start until a pending or active transmission has finished. If `wr_buf` and a reception start fall on the same edge, the transmission wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_tick | input | 1 | Phase-advance strobe |
| wr_buf | input | 1 | Buffer write pulse, starts a transmission |
| wr_byte | input | DATA_W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data line as seen at the pad |
| sd_out | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line output enable, high only while transmitting |
| sclk | output | 1 | Shift clock |
| rx_byte | output | DATA_W | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
A corrupted marker or a wrong shift direction shows up at the ports in one of two ways. Either a frame ends in the wrong cycle, so the done flag moves away from the slot-0 tick of cycle 10, or a data bit appears at `sd_out` one machine cycle early or late. Both are visible within ten machine cycles of the start. A slot counter that advances on a non-ticking clock moves the `sclk` low window out of slots 4 to 9 in the very next cycle. A broken start gate shows up as `sclk` toggling, or `sd_oe` rising, in a machine cycle where the bench expects the line to be idle.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Default geometry of the machine cycle.
  localparam int unsigned DEF_STATES = 6;
  localparam int unsigned DEF_PHASES = 2;

  // Slot index (0-based) of state st, phase ph (both 1-based).
  function automatic int unsigned slot_of(int unsigned st, int unsigned ph,
                                          int unsigned nph);
    return (st - 1) * nph + (ph - 1);
  endfunction

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_ARMED = 2'd2,
    TX_SEND  = 2'd3
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PEND = 2'd1,
    RX_LOAD = 2'd2,
    RX_RUN  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/sio_phase_seq.sv
module sio_phase_seq #(
  parameter int unsigned N_STATES = sio_pkg::DEF_STATES,
  parameter int unsigned N_PH     = sio_pkg::DEF_PHASES,
  parameter int unsigned SLOTS    = N_STATES * N_PH,
  parameter int unsigned PW       = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_tick,
  input  logic          active,
  output logic [PW-1:0] phase,
  output logic          s1p1,
  output logic          s5p2,
  output logic          s6p2,
  output logic          sclk
);
  import sio_pkg::*;

  localparam logic [PW-1:0] SL_FIRST = '0;
  localparam logic [PW-1:0] SL_LAST  = PW'(SLOTS - 1);
  localparam logic [PW-1:0] SL_S5P2  = PW'(slot_of(5, 2, N_PH));
  localparam logic [PW-1:0] SL_LOW0  = PW'(slot_of(3, 1, N_PH));
  localparam logic [PW-1:0] SL_HIGH0 = PW'(slot_of(6, 1, N_PH));

  logic in_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= SL_FIRST;
    end else if (ph_tick) begin
      phase <= (phase == SL_LAST) ? SL_FIRST : phase + 1'b1;
    end
  end

  assign s1p1 = ph_tick && (phase == SL_FIRST);
  assign s5p2 = ph_tick && (phase == SL_S5P2);
  assign s6p2 = ph_tick && (phase == SL_LAST);

  // Shift clock is low from the start of S3 to the end of S5.
  assign in_low = (phase >= SL_LOW0) && (phase < SL_HIGH0);
  assign sclk   = !(active && in_low);

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s1p1,
  input  logic         s6p2,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         blocked,
  input  logic         clr_done,
  output logic         busy,
  output logic         send,
  output logic         bit_out,
  output logic         done
);
  import sio_pkg::*;

  localparam logic [W-1:0] MARK = W'(1);

  tx_state_t    state;
  logic [W:0]   sr;
  logic         last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      sr    <= '0;
      last  <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (clr_done) done <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (wr && !blocked) begin
            sr    <= {1'b1, wr_data};
            state <= s6p2 ? TX_ARMED : TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (s6p2) state <= TX_ARMED;
        end
        TX_ARMED: begin
          if (s6p2) state <= TX_SEND;
        end
        TX_SEND: begin
          if (s6p2) begin
            sr <= {1'b0, sr[W:1]};
            if (sr[W:1] == MARK) last <= 1'b1;
          end
          if (s1p1 && last) begin
            state <= TX_IDLE;
            last  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy    = (state != TX_IDLE);
  assign send    = (state == TX_SEND);
  assign bit_out = sr[0];

endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s1p1,
  input  logic         s5p2,
  input  logic         s6p2,
  input  logic         rx_en,
  input  logic         clr_done,
  input  logic         tx_claim,
  input  logic         line_in,
  output logic         busy,
  output logic         run,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  import sio_pkg::*;

  localparam logic [W-1:0] PRESET = {{(W-1){1'b1}}, 1'b0};

  rx_state_t    state;
  logic [W-1:0] sr;
  logic [W-1:0] sr_rev;
  logic         smp;
  logic         last;
  logic         start_ok;

  // First bit received ends in the top of sr; it is the LSB of the byte.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign sr_rev[i] = sr[W-1-i];
  end

  assign start_ok = rx_en && (!done || clr_done) && !tx_claim;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      sr      <= '1;
      smp     <= 1'b1;
      last    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (clr_done) done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (s6p2 && start_ok) state <= RX_PEND;
        end
        RX_PEND: begin
          if (s6p2) begin
            sr    <= PRESET;
            state <= RX_LOAD;
          end
        end
        RX_LOAD: begin
          if (s1p1) state <= RX_RUN;
        end
        RX_RUN: begin
          if (s5p2) smp <= line_in;
          if (s6p2) begin
            sr <= {sr[W-2:0], smp};
            if (!sr[W-1]) last <= 1'b1;
          end
          if (s1p1 && last) begin
            state   <= RX_IDLE;
            last    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= sr_rev;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy = (state != RX_IDLE);
  assign run  = (state == RX_RUN);

endmodule

// File: rtl/sio_sync_port.sv
module sio_sync_port #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_STATES = sio_pkg::DEF_STATES,
  parameter int unsigned N_PH     = sio_pkg::DEF_PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph_tick,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rx_en,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_done,
  output logic              rx_done
);
  localparam int unsigned SLOTS = N_STATES * N_PH;
  localparam int unsigned PW    = $clog2(SLOTS);

  logic [PW-1:0] phase;
  logic          s1p1, s5p2, s6p2;
  logic          tx_busy, tx_send, tx_bit;
  logic          rx_busy, rx_run;
  logic          active;

  assign active = tx_send || rx_run;

  sio_phase_seq #(
    .N_STATES(N_STATES), .N_PH(N_PH), .SLOTS(SLOTS), .PW(PW)
  ) u_seq (
    .clk(clk), .rst(rst), .ph_tick(ph_tick), .active(active),
    .phase(phase), .s1p1(s1p1), .s5p2(s5p2), .s6p2(s6p2), .sclk(sclk)
  );

  sio_tx #(.W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .s1p1(s1p1), .s6p2(s6p2),
    .wr(wr_buf), .wr_data(wr_byte), .blocked(rx_busy),
    .clr_done(clr_tx_done), .busy(tx_busy), .send(tx_send),
    .bit_out(tx_bit), .done(tx_done)
  );

  sio_rx #(.W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .s1p1(s1p1), .s5p2(s5p2), .s6p2(s6p2),
    .rx_en(rx_en), .clr_done(clr_rx_done),
    .tx_claim(tx_busy || wr_buf), .line_in(sd_in),
    .busy(rx_busy), .run(rx_run), .done(rx_done), .rx_byte(rx_byte)
  );

  assign sd_oe  = tx_send;
  assign sd_out = tx_send ? tx_bit : 1'b1;

endmodule

// File: rtl/sio_sync_port_chk.sv
module sio_sync_port_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned PW    = 4,
  parameter int unsigned SLOTS = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          ph_tick,
  input logic [PW-1:0] phase,
  input logic          sd_oe,
  input logic          sclk,
  input logic          tx_done,
  input logic          rx_done,
  input logic [W-1:0]  rx_byte,
  input logic          rx_run
);
  localparam logic [PW-1:0] SL_LAST = PW'(SLOTS - 1);

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ph_tick |=> $stable(phase));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    ph_tick |=> (phase == (($past(phase) == SL_LAST) ? '0 : $past(phase) + 1'b1)));

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!sd_oe && !rx_run) |-> sclk);

  p_sclk_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !ph_tick |=> $stable(sclk));

  p_tx_end_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_oe) |-> $rose(tx_done));

  p_oe_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_oe) |-> $past(ph_tick));

  p_rxbyte_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> rx_done);

  p_half_duplex_r12: assert property (@(posedge clk) disable iff (rst)
    !(sd_oe && rx_run));

endmodule

bind sio_sync_port sio_sync_port_chk #(.W(DATA_W), .PW(PW), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .ph_tick(ph_tick), .phase(phase), .sd_oe(sd_oe),
  .sclk(sclk), .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte),
  .rx_run(rx_run)
);

// File: tb/test_sio_sync_port.sv
module test_sio_sync_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ph_tick = 1'b0;
  logic       wr_buf = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       rx_en = 1'b0;
  logic       clr_tx_done = 1'b0;
  logic       clr_rx_done = 1'b0;
  logic       sd_in = 1'b1;
  logic       sd_out, sd_oe, sclk, tx_done, rx_done;
  logic [7:0] rx_byte;

  int  checks = 0;
  int  errors = 0;
  int  bph = 0;     // slot the design is in, tracked by the bench
  int  gph = 0;     // total slots elapsed since reset
  bit  gap = 1'b0;  // tick only every other clock
  logic [7:0] exp_rx = '0;

  always #10 clk = ~clk;  // 50 MHz

  sio_sync_port i_sio_sync_port (
    .clk(clk), .rst(rst), .ph_tick(ph_tick), .wr_buf(wr_buf),
    .wr_byte(wr_byte), .rx_en(rx_en), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .sd_in(sd_in), .sd_out(sd_out),
    .sd_oe(sd_oe), .sclk(sclk), .rx_byte(rx_byte), .tx_done(tx_done),
    .rx_done(rx_done)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (slot %0d)", req, what, act, exp, bph);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    if (ph_tick) begin
      bph = (bph == 11) ? 0 : bph + 1;
      gph++;
    end
    @(negedge clk);
    ph_tick = gap ? ~ph_tick : 1'b1;
  endtask

  task automatic to_g(int t);
    while (gph < t) adv();
  endtask

  task automatic to_ph(int p);
    while (bph != p) adv();
  endtask

  task automatic pulse_wr(logic [7:0] d);
    wr_buf = 1'b1; wr_byte = d;
    adv();
    wr_buf = 1'b0;
  endtask

  task automatic clear_tx();
    clr_tx_done = 1'b1; adv(); clr_tx_done = 1'b0;
    chk("R6", "tx_done after clear", tx_done, 0);
  endtask

  // Transmit one byte; dup adds an ignored second write mid-frame.
  task automatic tx_frame(logic [7:0] d, bit dup, int wph);
    int t0;
    to_ph(wph); t0 = gph - wph;
    pulse_wr(d);
    to_g(t0 + 12 + 11);
    chk("R3", "oe in cycle 1", sd_oe, 0);
    to_g(t0 + 24);
    chk("R3", "oe at start of cycle 2", sd_oe, 1);
    for (int k = 0; k < 8; k++) begin
      to_g(t0 + 12 * (2 + k) + 5);
      chk("R5", "sclk low in S3..S5", sclk, 0);
      if (dup && k == 3) pulse_wr(~d);  // R11
      to_g(t0 + 12 * (2 + k) + 10);
      chk("R4", "tx data bit", sd_out, int'(d[k]));
      chk("R5", "sclk high in S6", sclk, 1);
    end
    to_g(t0 + 120);
    chk("R6", "tx_done before end", tx_done, 0);
    chk("R6", "oe before end", sd_oe, 1);
    to_g(t0 + 121);
    chk("R6", "tx_done at end", tx_done, 1);
    chk("R6", "oe at end", sd_oe, 0);
    if (dup) begin
      to_g(t0 + 12 * 12 + 5);
      chk("R11", "ignored write started no frame (oe)", sd_oe, 0);
      chk("R11", "ignored write started no frame (sclk)", sclk, 1);
    end
    clear_tx();
  endtask

  // Receive one byte; started by a flag clear at slot 4.
  task automatic rx_frame(logic [7:0] d, bit dup);
    int t0;
    to_ph(4); t0 = gph - 4;
    rx_en = 1'b1; clr_rx_done = 1'b1;
    adv();
    clr_rx_done = 1'b0;
    to_g(t0 + 12 + 5);
    chk("R7", "sclk idle in cycle 1", sclk, 1);
    for (int k = 0; k < 8; k++) begin
      to_g(t0 + 12 * (2 + k));
      sd_in = d[k];
      if (dup && k == 2) pulse_wr(8'h5A);  // R11
      to_g(t0 + 12 * (2 + k) + 5);
      chk("R5", "rx sclk low", sclk, 0);
      chk("R7", "oe stays low in rx", sd_oe, 0);
    end
    to_g(t0 + 120);
    chk("R9", "rx_done before end", rx_done, 0);
    chk("R9", "rx_byte held", int'(rx_byte), int'(exp_rx));
    to_g(t0 + 121);
    chk("R9", "rx_done at end", rx_done, 1);
    chk("R8", "rx_byte value", int'(rx_byte), int'(d));
    exp_rx = d;
    if (dup) begin
      to_g(t0 + 12 * 11 + 5);
      chk("R11", "write during rx ignored", sd_oe, 0);
      chk("R11", "write during rx no tx_done", tx_done, 0);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "oe", sd_oe, 0);
    chk("R1", "sclk", sclk, 1);
    chk("R1", "tx_done", tx_done, 0);
    chk("R1", "rx_done", rx_done, 0);
    chk("R1", "rx_byte", int'(rx_byte), 0);
    ph_tick = 1'b1;

    // Transmit sweep over all byte values.
    for (int v = 0; v < 256; v++) tx_frame(v[7:0], (v % 37) == 5, 4);

    // Write on the ticking edge of S6P2.
    tx_frame(8'hC3, 1'b0, 11);

    // Half-speed ticks: timing counts slots, not clocks (R2).
    gap = 1'b1;
    tx_frame(8'hA6, 1'b0, 4);
    rx_frame(8'h39, 1'b0);
    gap = 1'b0;
    to_ph(0);
    ph_tick = 1'b1;
    adv();

    // Receive sweep.
    for (int v = 0; v < 256; v++) rx_frame(8'(v * 7 + 3), (v % 41) == 7);

    // R10: flag set blocks a new reception.
    for (int c = 0; c < 3; c++) begin
      to_ph(5);
      chk("R10", "no rx while done set", sclk, 1);
      chk("R10", "rx_byte held while done set", int'(rx_byte), int'(exp_rx));
      adv();
    end
    // R10: enable low blocks a new reception.
    rx_en = 1'b0;
    clr_rx_done = 1'b1; adv(); clr_rx_done = 1'b0;
    for (int c = 0; c < 3; c++) begin
      to_ph(5);
      chk("R10", "no rx while disabled", sclk, 1);
      adv();
    end
    chk("R10", "rx_done stays low", rx_done, 0);

    // R12: reception held off until transmit finishes.
    begin
      int t0;
      logic [7:0] d1, d2;
      d1 = 8'h96; d2 = 8'h4B;
      to_ph(4); t0 = gph - 4;
      pulse_wr(d1);
      to_g(t0 + 36 + 4);
      rx_en = 1'b1;
      to_g(t0 + 60 + 10);
      chk("R12", "tx bit intact with rx pending", sd_out, int'(d1[3]));
      to_g(t0 + 121);
      chk("R12", "tx completes first", tx_done, 1);
      to_g(t0 + 132 + 5);
      chk("R12", "rx not yet shifting", sclk, 1);
      for (int k = 0; k < 8; k++) begin
        to_g(t0 + 12 * (12 + k));
        sd_in = d2[k];
        to_g(t0 + 12 * (12 + k) + 5);
        chk("R12", "rx shifting after tx", sclk, 0);
      end
      to_g(t0 + 240);
      chk("R12", "rx_done before end", rx_done, 0);
      to_g(t0 + 241);
      chk("R12", "rx_done after tx-delayed frame", rx_done, 1);
      chk("R12", "rx_byte after tx-delayed frame", int'(rx_byte), int'(d2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL WATCHDOG run hung: actual=timeout expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule